// File: doc/BRIEF.md
# Block-Cipher Decryption Host Interface

This block sits between a 32-bit register bus and a 128-bit block-cipher decryption engine. Software, or a DMA channel, writes a ciphertext block one word at a time. The block starts the engine, holds the result, and hands the plaintext back one word at a time. In chained (CBC) mode it XORs the engine output with a chaining register, then loads that register with the ciphertext it just used. The chaining value can therefore be read between blocks, saved, and written back later.

The cipher rounds are not part of this block. They are reached through a start/done port. The key registers are loaded by software, and after the first block they are replaced by the derived decryption key that the engine returns.

Clearing the enable bit stops the block. Software can then save the chaining value, restore it later, set enable again, and continue the message from the next block.

The data path uses the register bus with no back-pressure. Every bus access completes in the cycle it is presented. An access that arrives when the block cannot take it has no effect: a data-in write is dropped, and a data-out read returns zero. Flow is paced by the two DMA request outputs. Each request stays high while its side can take one more access.

Top module: `blk_dec_host`

Register word addresses:
- 0: control. Bit 0 enable, bit 1 CBC mode (0 selects ECB), bit 2 flag clear (write-only, reads 0), bit 3 input DMA enable, bit 4 output DMA enable.
- 1: status. Bit 0 is the completion flag.
- 2: data-in.
- 3: data-out.
- 4 to 7: chaining value, from bits 127:96 at address 4 down to bits 31:0 at address 7.
- 8 to 11: key, with the same word order.

## Requirements
- R1: A block is formed from four accepted data-in writes (address 2). The first write lands in bits 127:96 and the fourth in bits 31:0.
- R2: The fourth accepted write starts the engine exactly once. The flag (status bit 0) rises only after the engine reports done. A data-out read before that returns 0.
- R3: Four data-out reads (address 3) return the result from bits 127:96 down to bits 31:0. After the fourth read the block accepts new input, and further reads return 0.
- R4: The flag stays set until a control write with bit 2 set. Bit 2 always reads back as 0.
- R5: Data-in writes made while the engine is busy, or while a result is waiting to be read, have no effect.
- R6: The input DMA request is high only when enable and control bit 3 are both set and input is being collected.
- R7: The output DMA request is high only when enable and control bit 4 are both set and a result is waiting. The two requests are never high together.
- R8: In CBC mode (control bit 1 = 1), plaintext = engine output XOR chaining value. The chaining register then holds the ciphertext just consumed.
- R9: In ECB mode (control bit 1 = 0), plaintext = engine output, and the chaining register is left unchanged.
- R10: While enable is 0, the input and output word counts return to the first word and data-in writes are ignored. After the chaining value is restored and the block is re-enabled, the message continues correctly.
- R11: When a block completes, the key registers hold the key the engine returned, and `eng_key_drv` goes to 1. A key write clears it to 0.
- R12: After reset, every register reads 0 and both DMA requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read side effects take place at the clock edge |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| din_dma_req | output | 1 | Input side can take a data-in word |
| dout_dma_req | output | 1 | Output side has a data-out word |
| eng_start | output | 1 | One-cycle engine start pulse |
| eng_din | output | 128 | Ciphertext block sent to the engine |
| eng_key | output | 128 | Key register contents |
| eng_key_drv | output | 1 | Key registers already hold a derived key |
| eng_done | input | 1 | Engine result valid (pulse) |
| eng_dout | input | 128 | Engine output block |
| eng_key_out | input | 128 | Derived key returned by the engine |

## Verification
The assertions check these on every cycle:
- a start is always a single pulse;
- the flag only rises after an engine done;
- a clear write drops the flag;
- the word counters restart on load and on disable;
- the two DMA requests never overlap;
- in ECB mode the chaining value does not move unless written.

Only the bench scenarios can show the rest:
- word order within a block;
- the CBC arithmetic across several blocks;
- the derived key replacing the loaded one;
- the suspend sequence, where a partial block is abandoned and the message continues from a restored chaining value.

// File: rtl/blkdec_pkg.sv
package blkdec_pkg;
  typedef enum logic [1:0] {ST_FILL, ST_BUSY, ST_OUT, ST_DRAIN} seq_st_e;

  localparam int A_CTRL = 0;
  localparam int A_STAT = 1;
  localparam int A_DIN  = 2;
  localparam int A_DOUT = 3;
  localparam int A_IV   = 4;

  localparam int C_EN       = 0;
  localparam int C_CBC      = 1;
  localparam int C_CLR      = 2;
  localparam int C_DIN_DMA  = 3;
  localparam int C_DOUT_DMA = 4;
endpackage

// File: rtl/blkdec_fill.sv
module blkdec_fill #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    push,
  input  logic [WORD_W-1:0]       wdata,
  output logic [WORD_W*WORDS-1:0] blk,
  output logic                    last
);
  localparam int BLK_W = WORD_W * WORDS;
  localparam int CW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [CW-1:0] cnt_q;

  assign last = push && (cnt_q == CW'(WORDS - 1));

  // Shifting in at the low end leaves the first word at the top.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      blk   <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (push) begin
      blk   <= {blk[BLK_W-WORD_W-1:0], wdata};
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assert_fill_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  assert_fill_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr && !last) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/blkdec_chain.sv
module blkdec_chain #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [WORDS-1:0]                  iv_we,
  input  logic [WORD_W-1:0]                 wdata,
  input  logic                              upd,
  input  logic                              cbc,
  input  logic [WORD_W*WORDS-1:0]           ct,
  input  logic [WORD_W*WORDS-1:0]           eng_out,
  output logic [WORDS-1:0][WORD_W-1:0]      iv_q,
  output logic [WORD_W*WORDS-1:0]           pt
);
  assign pt = cbc ? (eng_out ^ iv_q) : eng_out;

  for (genvar j = 0; j < WORDS; j++) begin : g_iv
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           iv_q[j] <= '0;
      else if (upd && cbc)  iv_q[j] <= ct[j*WORD_W +: WORD_W];
      else if (iv_we[j])    iv_q[j] <= wdata;
    end
  end

  assert_ecb_iv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cbc && (iv_we == '0)) |=> $stable(iv_q));
endmodule

// File: rtl/blkdec_emit.sv
module blkdec_emit #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    load,
  input  logic [WORD_W*WORDS-1:0] load_data,
  input  logic                    pop,
  output logic [WORD_W-1:0]       word,
  output logic                    last
);
  localparam int BLK_W = WORD_W * WORDS;
  localparam int CW    = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [BLK_W-1:0] res_q;
  logic [CW-1:0]    cnt_q;

  assign word = res_q[BLK_W-1 -: WORD_W];
  assign last = pop && (cnt_q == CW'(WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (load) begin
      res_q <= load_data;
      cnt_q <= '0;
    end else if (pop) begin
      res_q <= res_q << WORD_W;
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assert_emit_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == '0));
  assert_emit_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/blk_dec_host.sv
module blk_dec_host
  import blkdec_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [WORD_W-1:0]       bus_wdata,
  output logic [WORD_W-1:0]       bus_rdata,
  output logic                    din_dma_req,
  output logic                    dout_dma_req,
  output logic                    eng_start,
  output logic [WORD_W*WORDS-1:0] eng_din,
  output logic [WORD_W*WORDS-1:0] eng_key,
  output logic                    eng_key_drv,
  input  logic                    eng_done,
  input  logic [WORD_W*WORDS-1:0] eng_dout,
  input  logic [WORD_W*WORDS-1:0] eng_key_out
);
  localparam int BLK_W    = WORD_W * WORDS;
  localparam int KEY_BASE = A_IV + WORDS;

  seq_st_e st_q, st_d;
  logic en_q, cbc_q, din_dma_q, dout_dma_q, flag_q, key_drv_q, start_q;
  logic [WORDS-1:0][WORD_W-1:0] key_q;
  logic [WORDS-1:0][WORD_W-1:0] iv_q;
  logic [WORDS-1:0] iv_we, key_we;
  logic [BLK_W-1:0] blk, pt;
  logic [WORD_W-1:0] out_word;
  logic ctrl_wr, din_push, dout_pop, accept, fill_last, emit_last;

  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign din_push = bus_wr && (bus_addr == ADDR_W'(A_DIN)) && en_q && (st_q == ST_FILL);
  assign dout_pop = bus_rd && (bus_addr == ADDR_W'(A_DOUT)) && en_q && (st_q == ST_OUT);
  assign accept   = eng_done && (st_q == ST_BUSY) && en_q;

  // Word j of a wide register sits at base + (WORDS-1-j): top word first.
  for (genvar j = 0; j < WORDS; j++) begin : g_dec
    assign iv_we[j]  = bus_wr && (bus_addr == ADDR_W'(A_IV + WORDS - 1 - j));
    assign key_we[j] = bus_wr && (bus_addr == ADDR_W'(KEY_BASE + WORDS - 1 - j));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         key_q[j] <= '0;
      else if (accept)    key_q[j] <= eng_key_out[j*WORD_W +: WORD_W];
      else if (key_we[j]) key_q[j] <= bus_wdata;
    end
  end

  blkdec_fill #(.WORD_W(WORD_W), .WORDS(WORDS)) u_fill (
    .clk(clk), .rst_n(rst_n), .clr(!en_q), .push(din_push),
    .wdata(bus_wdata), .blk(blk), .last(fill_last)
  );

  blkdec_chain #(.WORD_W(WORD_W), .WORDS(WORDS)) u_chain (
    .clk(clk), .rst_n(rst_n), .iv_we(iv_we), .wdata(bus_wdata),
    .upd(accept), .cbc(cbc_q), .ct(blk), .eng_out(eng_dout),
    .iv_q(iv_q), .pt(pt)
  );

  blkdec_emit #(.WORD_W(WORD_W), .WORDS(WORDS)) u_emit (
    .clk(clk), .rst_n(rst_n), .clr(!en_q), .load(accept),
    .load_data(pt), .pop(dout_pop), .word(out_word), .last(emit_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FILL:  if (fill_last) st_d = ST_BUSY;
      ST_BUSY: begin
        if (!en_q)         st_d = eng_done ? ST_FILL : ST_DRAIN;
        else if (eng_done) st_d = ST_OUT;
      end
      ST_OUT:   if (!en_q || emit_last) st_d = ST_FILL;
      ST_DRAIN: if (eng_done) st_d = ST_FILL;
      default:  st_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_FILL;
      en_q       <= 1'b0;
      cbc_q      <= 1'b0;
      din_dma_q  <= 1'b0;
      dout_dma_q <= 1'b0;
      flag_q     <= 1'b0;
      key_drv_q  <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= fill_last;
      if (ctrl_wr) begin
        en_q       <= bus_wdata[C_EN];
        cbc_q      <= bus_wdata[C_CBC];
        din_dma_q  <= bus_wdata[C_DIN_DMA];
        dout_dma_q <= bus_wdata[C_DOUT_DMA];
      end
      if (accept)                             flag_q <= 1'b1;
      else if (ctrl_wr && bus_wdata[C_CLR])   flag_q <= 1'b0;
      if (accept)                             key_drv_q <= 1'b1;
      else if (|key_we)                       key_drv_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CTRL)) begin
      bus_rdata[C_EN]       = en_q;
      bus_rdata[C_CBC]      = cbc_q;
      bus_rdata[C_DIN_DMA]  = din_dma_q;
      bus_rdata[C_DOUT_DMA] = dout_dma_q;
    end else if (bus_addr == ADDR_W'(A_STAT)) begin
      bus_rdata[0] = flag_q;
    end else if (bus_addr == ADDR_W'(A_DOUT)) begin
      if (en_q && (st_q == ST_OUT)) bus_rdata = out_word;
    end
    for (int j = 0; j < WORDS; j++) begin
      if (bus_addr == ADDR_W'(A_IV + WORDS - 1 - j))     bus_rdata = iv_q[j];
      if (bus_addr == ADDR_W'(KEY_BASE + WORDS - 1 - j)) bus_rdata = key_q[j];
    end
  end

  assign din_dma_req  = en_q && din_dma_q && (st_q == ST_FILL);
  assign dout_dma_req = en_q && dout_dma_q && (st_q == ST_OUT);
  assign eng_start    = start_q;
  assign eng_din      = blk;
  assign eng_key      = key_q;
  assign eng_key_drv  = key_drv_q;

  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  assert_flag_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(eng_done));
  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[C_CLR] && !accept) |=> !flag_q);
  assert_req_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(din_dma_req && dout_dma_req));
  assert_start_from_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (st_q == ST_BUSY || st_q == ST_DRAIN));
endmodule

// File: tb/test_blk_dec_host.sv
module test_blk_dec_host;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_DIN = 4'd2, A_DOUT = 4'd3;
  localparam logic [3:0] A_IV = 4'd4, A_KEY = 4'd8;
  localparam logic [31:0] C_EN = 32'h1, C_CBC = 32'h2, C_CLR = 32'h4;
  localparam logic [31:0] C_DIND = 32'h8, C_DOUTD = 32'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic din_dma_req, dout_dma_req, eng_start, eng_key_drv;
  logic [127:0] eng_din, eng_key;
  logic eng_done;
  logic [127:0] eng_dout, eng_key_out;

  int total = 0;
  int bad = 0;
  int starts = 0;
  logic [127:0] cap_din, cap_key;
  logic cap_drv;
  logic [2:0] lat;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_dec_host i_blk_dec_host (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .din_dma_req(din_dma_req), .dout_dma_req(dout_dma_req),
    .eng_start(eng_start), .eng_din(eng_din), .eng_key(eng_key),
    .eng_key_drv(eng_key_drv), .eng_done(eng_done), .eng_dout(eng_dout),
    .eng_key_out(eng_key_out)
  );

  // Reversible stand-in engine: derived key = ~key, output = input ^ derived key.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_done <= 1'b0; eng_dout <= '0; eng_key_out <= '0; lat <= '0;
      cap_din <= '0; cap_key <= '0; cap_drv <= 1'b0;
    end else begin
      eng_done <= 1'b0;
      if (eng_start) begin
        cap_din <= eng_din;
        cap_key <= eng_key_drv ? eng_key : ~eng_key;
        cap_drv <= eng_key_drv;
        starts  <= starts + 1;
        lat     <= 3'd3;
      end else if (lat != 0) begin
        lat <= lat - 1'b1;
        if (lat == 3'd1) begin
          eng_done    <= 1'b1;
          eng_dout    <= cap_din ^ cap_key;
          eng_key_out <= cap_key;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wr_wide(input logic [3:0] base, input logic [127:0] v);
    for (int i = 3; i >= 0; i--) wr(base + 4'(3 - i), v[i*32 +: 32]);
  endtask

  task automatic rd_wide(input logic [3:0] base, output logic [127:0] v);
    logic [31:0] w;
    for (int i = 3; i >= 0; i--) begin rd(base + 4'(3 - i), w); v[i*32 +: 32] = w; end
  endtask

  task automatic wr_blk(input logic [127:0] v);
    for (int i = 3; i >= 0; i--) wr(A_DIN, v[i*32 +: 32]);
  endtask

  task automatic rd_blk(output logic [127:0] v);
    logic [31:0] w;
    for (int i = 3; i >= 0; i--) begin rd(A_DOUT, w); v[i*32 +: 32] = w; end
  endtask

  task automatic wait_flag(input string req);
    logic [31:0] s;
    s = '0;
    for (int n = 0; n < 40 && !s[0]; n++) rd(A_STAT, s);
    chk(req, {127'b0, s[0]}, 128'd1);
  endtask

  localparam logic [127:0] K  = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
  localparam logic [127:0] DK = ~K;
  localparam logic [127:0] V  = 128'h11112222_33334444_55556666_77778888;

  task automatic t_reset();
    logic [31:0] w;
    logic [127:0] v;
    rd(A_CTRL, w); chk("R12 ctrl", 128'(w), 0);
    rd(A_STAT, w); chk("R12 stat", 128'(w), 0);
    rd_wide(A_IV, v); chk("R12 iv", v, 0);
    chk("R12 dma reqs", {126'b0, din_dma_req, dout_dma_req}, 0);
  endtask

  task automatic t_ecb_first();
    logic [31:0] w;
    logic [127:0] c, p, v;
    c = 128'hdeadbeef_01234567_89abcdef_cafef00d;
    wr_wide(A_KEY, K);
    wr_wide(A_IV, V);
    wr(A_CTRL, C_EN);
    rd(A_DOUT, w); chk("R2 dout before flag", 128'(w), 0);
    wr_blk(c);
    wait_flag("R2 flag after done");
    chk("R1 block order", cap_din, c);
    chk("R11 first block uses loaded key", {127'b0, cap_drv}, 0);
    rd_blk(p); chk("R3 ecb output order", p, c ^ DK);
    rd(A_DOUT, w); chk("R3 fifth read zero", 128'(w), 0);
    rd_wide(A_KEY, v); chk("R11 derived key stored", v, DK);
    chk("R11 drv flag", {127'b0, eng_key_drv}, 1);
    rd_wide(A_IV, v); chk("R9 ecb iv untouched", v, V);
  endtask

  task automatic t_clear();
    logic [31:0] w;
    rd(A_STAT, w); chk("R4 flag sticky", 128'(w[0]), 1);
    wr(A_CTRL, C_EN | C_CLR);
    rd(A_STAT, w); chk("R4 flag cleared", 128'(w[0]), 0);
    rd(A_CTRL, w); chk("R4 clr reads 0", 128'(w), 128'(C_EN));
  endtask

  task automatic t_ignore();
    logic [127:0] c, p;
    int s0;
    c = 128'h00000001_00000002_00000003_00000004;
    s0 = starts;
    wr_blk(c);
    wr(A_DIN, 32'hffffffff);
    wait_flag("R5 flag");
    wr(A_DIN, 32'heeeeeeee);
    chk("R5 one start", 128'(starts - s0), 1);
    chk("R11 derived key reused", {127'b0, cap_drv}, 1);
    rd_blk(p); chk("R5 extra writes ignored", p, c ^ DK);
    wr(A_CTRL, C_EN | C_CLR);
  endtask

  task automatic t_dma();
    logic [127:0] c, p;
    c = 128'h5a5a5a5a_a5a5a5a5_0f0f0f0f_f0f0f0f0;
    wr(A_CTRL, C_EN | C_DIND); #1;
    chk("R6 din req on", {127'b0, din_dma_req}, 1);
    wr(A_CTRL, C_EN); #1;
    chk("R6 din req gated", {127'b0, din_dma_req}, 0);
    wr(A_CTRL, C_EN | C_DOUTD); #1;
    chk("R7 dout req idle", {127'b0, dout_dma_req}, 0);
    wr_blk(c);
    wait_flag("R7 flag");
    chk("R7 dout req on", {126'b0, dout_dma_req, din_dma_req}, 2);
    wr(A_CTRL, C_EN); #1;
    chk("R7 dout req gated", {127'b0, dout_dma_req}, 0);
    wr(A_CTRL, C_EN | C_DOUTD | C_CLR);
    rd_blk(p); #1;
    chk("R7 result", p, c ^ DK);
    chk("R7 dout req after drain", {127'b0, dout_dma_req}, 0);
  endtask

  task automatic t_cbc();
    logic [127:0] ca, cb, p, v;
    ca = 128'h13579bdf_2468ace0_fedcba98_76543210;
    cb = 128'h99990000_aaaa1111_bbbb2222_cccc3333;
    wr_wide(A_IV, V);
    wr(A_CTRL, C_EN | C_CBC | C_CLR);
    wr_blk(ca); wait_flag("R8 flag a");
    rd_blk(p); chk("R8 cbc block a", p, ca ^ DK ^ V);
    rd_wide(A_IV, v); chk("R8 iv holds ct a", v, ca);
    wr(A_CTRL, C_EN | C_CBC | C_CLR);
    wr_blk(cb); wait_flag("R8 flag b");
    rd_blk(p); chk("R8 cbc block b", p, cb ^ DK ^ ca);
  endtask

  task automatic t_suspend();
    logic [127:0] ca, cb, p, saved;
    logic [31:0] w;
    ca = 128'h01010101_02020202_03030303_04040404;
    cb = 128'hf0e0d0c0_b0a09080_70605040_30201000;
    wr(A_CTRL, C_EN | C_CBC | C_CLR);
    wr_blk(ca); wait_flag("R10 flag a");
    rd_blk(p); chk("R10 block a", p, ca ^ DK ^ 128'hcccc3333 ^ {96'h99990000_aaaa1111_bbbb2222, 32'h0});
    rd_wide(A_IV, saved); chk("R10 saved iv", saved, ca);
    wr(A_DIN, 32'h12345678); wr(A_DIN, 32'h9abcdef0);
    wr(A_CTRL, 32'h0);
    wr(A_DIN, 32'h55555555);
    rd(A_DOUT, w); chk("R10 dout zero when off", 128'(w), 0);
    wr_wide(A_IV, 128'hbad0bad0_bad0bad0_bad0bad0_bad0bad0);
    wr_wide(A_IV, saved);
    wr(A_CTRL, C_EN | C_CBC | C_CLR);
    wr_blk(cb); wait_flag("R10 flag b");
    chk("R10 resumed block order", cap_din, cb);
    rd_blk(p); chk("R10 resumed output", p, cb ^ DK ^ ca);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ecb_first();
    t_clear();
    t_ignore();
    t_dma();
    t_cbc();
    t_suspend();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule